// File: doc/BRIEF.md
# Single-Wire Bus Slot Timing Master

This block is the master side of an open-drain single-wire bus. It turns one command into precise line activity. The commands are a bus reset with presence detection, a single written bit, a single read bit, a written byte, a read byte, or a touch byte. A touch byte both sends and samples. All timing counts a microsecond tick, which is derived from the system clock. Every slot interval is stretched by an integer delay coefficient supplied on a port, so the same block can drive slow or long cables.

The line itself is handled outside the block. The block asserts an active-high pull-down request, and it reads the line level back through a two-flop synchronizer. A separate enable output drives a strong pull-up. An agent can book this pull-up for the next written byte. Byte transfers run least-significant bit first. A controller issues a command while `busy` is low and waits for the one-clock `done` pulse. It then reads the byte result or the presence flag.

Top module: `onewire_slot_master`

## Requirements
- R1: A write-1 slot pulls the line low for 6·k µs, then releases it for 64·k µs, where k is the effective coefficient.
- R2: A write-0 slot pulls the line low for 60·k µs, then releases it for 10·k µs.
- R3: A read slot pulls low for 6·k µs and releases. It samples the synchronized line 9·k µs after release and then recovers for 55·k µs. A read-bit command returns the sampled level in `dataOut` bit 0, with bits 7..1 zero.
- R4: A reset pulls low for 500·k µs and samples 70·k µs after release. It then waits 430·k µs, for 1000·k µs in total. `presence` becomes 0 when the line was low at the sample point and 1 when it was high.
- R5: The effective coefficient k equals `delayCoef`, except that a value of 0 is treated as 1.
- R6: Byte commands move bit 0 first. A read byte uses eight read slots and returns the sampled bits in order. A touch byte uses a read slot for each 1 bit and a write-0 slot for each 0 bit. Its result holds the sampled level for 1 bits and 0 for 0 bits.
- R7: The command codes are 0 reset, 1 write bit (`dataIn` bit 0), 2 read bit, 3 write byte, 4 read byte and 5 touch byte. A command is taken only when `cmdValid` is high and `busy` is low. Codes 6 and 7, and any command presented while busy, are ignored. `busy` spans one set-up clock plus the slot time, and `done` is high for exactly one clock with `busy` low.
- R8: A pull-up request carries a nonzero duration D in µs, which is not scaled by k. It arms the next write-byte or touch-byte command. `strongPullup` rises when the line is released in bit 7 and stays high through the rest of that slot and for D µs after it. The request is then consumed, so the following byte gets no pull-up.
- R9: A request with D = 0 cancels a pending request. A request presented while `busy` is high is ignored.
- R10: `strongPullup` and `busLow` are never high together.
- R11: After reset, `busy`, `done`, `busLow`, `strongPullup` and `dataOut` are 0 and `presence` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | Command code |
| dataIn | input | 8 | Byte to send, or bit 0 for a single write |
| delayCoef | input | COEF_W | Slot time multiplier |
| pullupSet | input | 1 | Loads a pull-up request |
| pullupUs | input | PULL_W | Pull-up hold time in µs, 0 cancels |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock end-of-operation pulse |
| dataOut | output | 8 | Result of the last read or touch |
| presence | output | 1 | 0 = device answered the last reset |
| busLow | output | 1 | Pull the line low when high |
| busSense | input | 1 | Line level, asynchronous |
| strongPullup | output | 1 | Strong pull-up enable |

## Verification
The embedded properties watch the handshake on every cycle. They check that a legal idle command raises `busy` and an illegal code does not, that `done` never overlaps `busy`, and that the line is only driven while an operation runs. They also check that the pull-down and the strong pull-up never fight, and that arming happens only with a pending request. Slot lengths, sample instants, bit order, presence polarity and the one-shot nature of the pull-up can only be seen in the bench's scenarios. There, a device model answers read slots and resets, and the bench counts clocks of each low pulse and of each pull-up window.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [2:0] {
    OP_RESET = 3'd0,
    OP_WBIT  = 3'd1,
    OP_RBIT  = 3'd2,
    OP_WBYTE = 3'd3,
    OP_RBYTE = 3'd4,
    OP_TOUCH = 3'd5
  } op_e;

  typedef enum logic [3:0] {
    PH_RST_LOW, PH_RST_REL, PH_RST_REC,
    PH_W0_LOW,  PH_W0_REL,
    PH_W1_LOW,  PH_W1_REL,
    PH_RD_LOW,  PH_RD_REL,  PH_RD_REC,
    PH_PULL
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   load;        // start a timed phase
    phase_e phase;       // which phase to start
    logic   loadShift;   // capture dataIn into the shifter
    logic   loadOnes;    // shifter gets all ones (read ops)
    logic   shift;       // end of a bit slot
    logic   sample;      // take the read-slot sample
    logic   presence;    // take the reset presence sample
    logic   capture;     // update dataOut
    logic   captureByte; // full byte vs single bit result
    logic   arm;         // strong pull-up armed for bit 7
    logic   disarm;      // pull-up finished, consume request
  } strobe_t;

  // nominal phase length in microseconds, before the coefficient
  function automatic logic [9:0] phaseUs(phase_e p);
    case (p)
      PH_RST_LOW: phaseUs = 10'd500;
      PH_RST_REL: phaseUs = 10'd70;
      PH_RST_REC: phaseUs = 10'd430;
      PH_W0_LOW:  phaseUs = 10'd60;
      PH_W0_REL:  phaseUs = 10'd10;
      PH_W1_LOW:  phaseUs = 10'd6;
      PH_W1_REL:  phaseUs = 10'd64;
      PH_RD_LOW:  phaseUs = 10'd6;
      PH_RD_REL:  phaseUs = 10'd9;
      PH_RD_REC:  phaseUs = 10'd55;
      default:    phaseUs = 10'd0;
    endcase
  endfunction

  function automatic logic isLowPhase(phase_e p);
    return p inside {PH_RST_LOW, PH_W0_LOW, PH_W1_LOW, PH_RD_LOW};
  endfunction

endpackage

// File: rtl/owm_control.sv
module owm_control
  import owm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       phaseEnd,
  input  logic       curBit,
  input  logic       nextBit,
  input  logic       pullPending,
  output strobe_t    stb,
  output logic       busy,
  output logic       done
);

  typedef enum logic [1:0] {S_IDLE, S_START, S_SLOT, S_PULL} state_e;

  state_e     state;
  op_e        opQ;
  phase_e     phaseQ;
  logic [2:0] bitCnt;
  logic       pullOn;
  logic       doneQ;
  logic       accept, fin, lastBit, byteOp, writesByte;

  function automatic phase_e lowFor(op_e op, logic b);
    case (op)
      OP_RESET:          lowFor = PH_RST_LOW;
      OP_WBIT, OP_WBYTE: lowFor = b ? PH_W1_LOW : PH_W0_LOW;
      OP_TOUCH:          lowFor = b ? PH_RD_LOW : PH_W0_LOW;
      default:           lowFor = PH_RD_LOW;
    endcase
  endfunction

  assign accept     = cmdValid && (state == S_IDLE) && (cmdOp <= 3'd5);
  assign byteOp     = opQ inside {OP_WBYTE, OP_RBYTE, OP_TOUCH};
  assign writesByte = opQ inside {OP_WBYTE, OP_TOUCH};
  assign lastBit    = !byteOp || (bitCnt == 3'd7);

  always_comb begin
    stb       = '0;
    stb.phase = PH_RST_LOW;
    fin       = 1'b0;
    case (state)
      S_IDLE: if (accept) begin
        stb.loadShift = 1'b1;
        stb.loadOnes  = cmdOp inside {3'd2, 3'd4};
      end
      S_START: begin
        stb.load  = 1'b1;
        stb.phase = lowFor(opQ, curBit);
      end
      S_SLOT: if (phaseEnd) begin
        case (phaseQ)
          PH_RST_LOW: begin stb.load = 1'b1; stb.phase = PH_RST_REL; end
          PH_RST_REL: begin stb.presence = 1'b1; stb.load = 1'b1; stb.phase = PH_RST_REC; end
          PH_W0_LOW:  begin stb.load = 1'b1; stb.phase = PH_W0_REL; end
          PH_W1_LOW:  begin stb.load = 1'b1; stb.phase = PH_W1_REL; end
          PH_RD_LOW:  begin stb.load = 1'b1; stb.phase = PH_RD_REL; end
          PH_RD_REL:  begin stb.sample = 1'b1; stb.load = 1'b1; stb.phase = PH_RD_REC; end
          PH_RST_REC: fin = 1'b1;
          default: begin
            stb.shift = 1'b1;
            if (lastBit) begin
              stb.capture     = opQ inside {OP_RBIT, OP_RBYTE, OP_TOUCH};
              stb.captureByte = byteOp;
              if (pullOn) begin
                stb.load  = 1'b1;
                stb.phase = PH_PULL;
              end else begin
                fin = 1'b1;
              end
            end else begin
              stb.load  = 1'b1;
              stb.phase = lowFor(opQ, nextBit);
              stb.arm   = writesByte && (bitCnt == 3'd6) && pullPending;
            end
          end
        endcase
      end
      S_PULL: if (phaseEnd) begin
        stb.disarm = 1'b1;
        fin        = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      opQ    <= OP_RESET;
      phaseQ <= PH_RST_LOW;
      bitCnt <= '0;
      pullOn <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= fin;
      if (stb.load) phaseQ <= stb.phase;
      if (stb.arm) pullOn <= 1'b1;
      else if (fin) pullOn <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          opQ    <= op_e'(cmdOp);
          bitCnt <= '0;
          state  <= S_START;
        end
        S_START: state <= S_SLOT;
        S_SLOT: begin
          if (stb.load && stb.phase == PH_PULL) state <= S_PULL;
          else if (fin) state <= S_IDLE;
          if (stb.shift && !lastBit) bitCnt <= bitCnt + 3'd1;
        end
        S_PULL: if (fin) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
  assign done = doneQ;

  assert_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && cmdOp <= 3'd5) |=> busy);
  assert_bad_op_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && cmdOp > 3'd5) |=> !busy);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

endmodule

// File: rtl/owm_datapath.sv
module owm_datapath
  import owm_pkg::*;
#(
  parameter int CLKS_PER_US = 50,
  parameter int COEF_W      = 4,
  parameter int PULL_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [7:0]        dataIn,
  input  logic [COEF_W-1:0] delayCoef,
  input  logic              pullSet,
  input  logic [PULL_W-1:0] pullDur,
  input  logic              senseRaw,
  output logic              phaseEnd,
  output logic              curBit,
  output logic              nextBit,
  output logic              pullPending,
  output logic              busLow,
  output logic              strongPullup,
  output logic              presence,
  output logic [7:0]        dataOut
);

  localparam int PRE_W  = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam int SLOT_W = 10 + COEF_W;
  localparam int TMR_W  = (SLOT_W > PULL_W) ? SLOT_W : PULL_W;

  logic [PRE_W-1:0]  preCnt;
  logic              tick;
  logic [TMR_W-1:0]  tmr, loadVal;
  logic [COEF_W-1:0] coefEff;
  logic [1:0]        syncQ;
  logic              senseSync;
  logic [7:0]        shReg, outQ;
  logic              sampleQ, driveQ, presQ, armedQ;
  logic [PULL_W-1:0] pendQ;

  assign coefEff = (delayCoef == '0) ? COEF_W'(1) : delayCoef;

  always_comb begin
    if (stb.phase == PH_PULL) loadVal = TMR_W'(pendQ);
    else loadVal = TMR_W'(SLOT_W'(phaseUs(stb.phase)) * SLOT_W'(coefEff));
  end

  // microsecond tick, realigned to every phase start
  assign tick     = (preCnt == PRE_W'(CLKS_PER_US - 1));
  assign phaseEnd = tick && (tmr == TMR_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      tmr    <= '0;
    end else begin
      if (stb.load || tick) preCnt <= '0;
      else preCnt <= preCnt + PRE_W'(1);
      if (stb.load) tmr <= loadVal;
      else if (tick && tmr != '0) tmr <= tmr - TMR_W'(1);
    end
  end

  // line sense synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else syncQ <= {syncQ[0], senseRaw};
  end
  assign senseSync = syncQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      driveQ  <= 1'b0;
      shReg   <= '0;
      sampleQ <= 1'b0;
      outQ    <= '0;
      presQ   <= 1'b1;
      pendQ   <= '0;
      armedQ  <= 1'b0;
    end else begin
      if (stb.load) driveQ <= isLowPhase(stb.phase);
      if (stb.loadShift) shReg <= stb.loadOnes ? 8'hFF : dataIn;
      else if (stb.shift) shReg <= {sampleQ, shReg[7:1]};
      if (stb.load && isLowPhase(stb.phase)) sampleQ <= 1'b0;
      else if (stb.sample) sampleQ <= senseSync;
      if (stb.capture) outQ <= stb.captureByte ? {sampleQ, shReg[7:1]} : {7'd0, sampleQ};
      if (stb.presence) presQ <= senseSync;
      if (stb.disarm) pendQ <= '0;
      else if (pullSet) pendQ <= pullDur;
      if (stb.arm) armedQ <= 1'b1;
      else if (stb.disarm) armedQ <= 1'b0;
    end
  end

  assign curBit       = shReg[0];
  assign nextBit      = shReg[1];
  assign pullPending  = (pendQ != '0);
  assign busLow       = driveQ;
  assign strongPullup = armedQ & ~driveQ;
  assign presence     = presQ;
  assign dataOut      = outQ;

  assert_arm_pending_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.arm |-> pullPending);
  assert_low_timed_R1: assert property (@(posedge clk) disable iff (!rstN)
    busLow |-> (tmr != '0));

endmodule

// File: rtl/onewire_slot_master.sv
module onewire_slot_master
  import owm_pkg::*;
#(
  parameter int CLKS_PER_US = 50,
  parameter int COEF_W      = 4,
  parameter int PULL_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [7:0]        dataIn,
  input  logic [COEF_W-1:0] delayCoef,
  input  logic              pullupSet,
  input  logic [PULL_W-1:0] pullupUs,
  output logic              busy,
  output logic              done,
  output logic [7:0]        dataOut,
  output logic              presence,
  output logic              busLow,
  input  logic              busSense,
  output logic              strongPullup
);

  strobe_t stb;
  logic    phaseEnd, curBit, nextBit, pullPending;

  owm_control u_ctl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .phaseEnd(phaseEnd), .curBit(curBit), .nextBit(nextBit),
    .pullPending(pullPending), .stb(stb), .busy(busy), .done(done)
  );

  owm_datapath #(.CLKS_PER_US(CLKS_PER_US), .COEF_W(COEF_W), .PULL_W(PULL_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dataIn(dataIn), .delayCoef(delayCoef),
    .pullSet(pullupSet & ~busy), .pullDur(pullupUs), .senseRaw(busSense),
    .phaseEnd(phaseEnd), .curBit(curBit), .nextBit(nextBit),
    .pullPending(pullPending), .busLow(busLow), .strongPullup(strongPullup),
    .presence(presence), .dataOut(dataOut)
  );

  assert_no_fight_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(busLow && strongPullup));
  assert_low_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    busLow |-> busy);

endmodule

// File: tb/sim_onewire_slot_master.sv
module sim_onewire_slot_master;
  localparam int C = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, cmdValid = 1'b0, pullupSet = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [7:0] dataIn = '0;
  logic [3:0] delayCoef = 4'd1;
  logic [15:0] pullupUs = '0;
  logic busy, done, busLow, strongPullup, presence, busSense;
  logic [7:0] dataOut;
  logic devPull = 1'b0;

  assign busSense = ~(busLow | devPull);

  onewire_slot_master #(.CLKS_PER_US(C)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .dataIn(dataIn),
    .delayCoef(delayCoef), .pullupSet(pullupSet), .pullupUs(pullupUs),
    .busy(busy), .done(done), .dataOut(dataOut), .presence(presence),
    .busLow(busLow), .busSense(busSense), .strongPullup(strongPullup)
  );

  int total = 0, bad = 0;
  logic finished = 1'b0;

  // device model and counters
  int lowCnt = 0, relCnt = 0, nSlot = 0, devSlots = 0, busyCnt = 0, pullCnt = 0;
  int lowLog [64];
  int kNow = 1, devBase = 0, pullS = 0, pullE = 0;
  logic pullEn = 1'b0, prevLow = 1'b0, devPresent = 1'b1;
  logic [7:0] devByte = 8'hFF;

  always @(negedge clk) begin
    if (busy) busyCnt++;
    if (strongPullup) pullCnt++;
    if (busLow) begin
      lowCnt++;
      pullEn = 1'b0;
    end else if (prevLow) begin
      lowLog[nSlot % 64] = lowCnt;
      nSlot++;
      relCnt = 0;
      if (lowCnt >= 300 * kNow * C) begin
        pullEn = devPresent; pullS = 20 * kNow * C; pullE = 140 * kNow * C;
      end else begin
        pullEn = (lowCnt < 30 * kNow * C) && !devByte[(devSlots - devBase) % 8];
        devSlots++;
        pullS = 0; pullE = 12 * kNow * C;
      end
      lowCnt = 0;
    end else begin
      relCnt++;
    end
    devPull = pullEn && (relCnt >= pullS) && (relCnt < pullE);
    prevLow = busLow;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int lastBusy, lastSlots, lastPull, lastS0;

  task automatic runOp(input int op, input int din, input int k, input bit disturb);
    int b0, p0, guard;
    kNow = (k == 0) ? 1 : k;
    delayCoef = 4'(k);
    devBase = devSlots;
    lastS0 = nSlot; b0 = busyCnt; p0 = pullCnt;
    @(negedge clk); cmdValid = 1'b1; cmdOp = 3'(op); dataIn = 8'(din);
    @(negedge clk); cmdValid = 1'b0;
    guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (disturb && guard == 10) begin
        cmdValid = 1'b1; cmdOp = 3'd0; pullupSet = 1'b1; pullupUs = 16'd40;
      end else if (disturb && guard == 11) begin
        cmdValid = 1'b0; pullupSet = 1'b0;
      end
    end
    if (!done) check("R7 op never completed", 0, 1);
    lastBusy = busyCnt - b0; lastSlots = nSlot - lastS0; lastPull = pullCnt - p0;
  endtask

  task automatic setPull(input int d);
    @(negedge clk); pullupSet = 1'b1; pullupUs = 16'(d);
    @(negedge clk); pullupSet = 1'b0;
  endtask

  // {op[3], din[8], dev[8], k[4], chk[1], exp[8]}
  localparam logic [31:0] VECS [10] = '{
    {3'd3, 8'hA5, 8'hFF, 4'd1, 1'b0, 8'h00},
    {3'd3, 8'h3C, 8'hFF, 4'd2, 1'b0, 8'h00},
    {3'd4, 8'h00, 8'h96, 4'd1, 1'b1, 8'h96},
    {3'd4, 8'h00, 8'h00, 4'd1, 1'b1, 8'h00},
    {3'd5, 8'hF0, 8'h5A, 4'd1, 1'b1, 8'h50},
    {3'd5, 8'hFF, 8'hC3, 4'd2, 1'b1, 8'hC3},
    {3'd1, 8'h01, 8'hFF, 4'd1, 1'b0, 8'h00},
    {3'd1, 8'h00, 8'hFF, 4'd0, 1'b0, 8'h00},
    {3'd2, 8'h00, 8'h00, 4'd1, 1'b1, 8'h00},
    {3'd2, 8'h00, 8'hFF, 4'd1, 1'b1, 8'h01}
  };

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 busy", busy, 0);
    check("R11 done", done, 0);
    check("R11 busLow", busLow, 0);
    check("R11 strongPullup", strongPullup, 0);
    check("R11 presence", presence, 1);
    check("R11 dataOut", dataOut, 0);

    for (int i = 0; i < 10; i++) begin
      logic [31:0] v;
      int op, din, k, keff, nb, wr, badLow, expWr;
      v = VECS[i];
      op = v[31:29]; din = v[28:21]; k = v[12:9];
      devByte = v[20:13];
      keff = (k == 0) ? 1 : k;
      runOp(op, din, k, 1'b0);
      nb = (op >= 3) ? 8 : 1;
      check("R5 busy length scales with coefficient", lastBusy, 1 + 70 * nb * keff * C);
      check("R6 slot count", lastSlots, nb);
      wr = 0; badLow = 0;
      for (int j = 0; j < nb; j++) begin
        int len;
        len = lowLog[(lastS0 + j) % 64];
        if (len == 6 * keff * C) wr |= (1 << j);
        else if (len != 60 * keff * C) badLow++;
      end
      check("R1 R2 low pulse widths", badLow, 0);
      expWr = (op == 2 || op == 4) ? ((1 << nb) - 1) : (din & ((1 << nb) - 1));
      check("R6 bit order on line", wr, expWr);
      if (v[8]) check("R3 R6 dataOut", dataOut, v[7:0]);
    end

    // R7 done is a single clock
    @(negedge clk);
    check("R7 done one clock", done, 0);

    // R4 reset with and without a device
    devPresent = 1'b1;
    runOp(0, 0, 1, 1'b0);
    check("R4 presence with device", presence, 0);
    check("R4 reset duration", lastBusy, 1 + 1000 * C);
    check("R4 reset low width", lowLog[lastS0 % 64], 500 * C);
    devPresent = 1'b0;
    runOp(0, 0, 2, 1'b0);
    check("R4 presence no device", presence, 1);
    check("R5 reset low width k=2", lowLog[lastS0 % 64], 1000 * C);
    devPresent = 1'b1;

    // R7 illegal code ignored
    @(negedge clk); cmdValid = 1'b1; cmdOp = 3'd6; delayCoef = 4'd1;
    @(negedge clk); cmdValid = 1'b0;
    check("R7 code 6 ignored busy", busy, 0);
    @(negedge clk);
    check("R7 code 6 ignored done", done, 0);

    // R7 R9 command and pull-up request while busy are dropped
    devByte = 8'hFF;
    runOp(1, 1, 1, 1'b1);
    check("R7 busy command ignored", lastSlots, 1);
    check("R7 busy command ignored length", lastBusy, 1 + 70 * C);
    runOp(3, 8'h5A, 1, 1'b0);
    check("R9 request while busy dropped", lastPull, 0);

    // R8 pull-up after write byte, bit 7 = 0
    setPull(40);
    runOp(3, 8'h5A, 1, 1'b0);
    check("R8 pull-up window write", lastPull, (10 + 40) * C);
    check("R8 busy includes hold", lastBusy, 1 + 560 * C + 40 * C);
    runOp(3, 8'h5A, 1, 1'b0);
    check("R8 one-shot", lastPull, 0);

    // R8 pull-up after touch byte, bit 7 = 1
    setPull(40);
    devByte = 8'hC3;
    runOp(5, 8'hFF, 1, 1'b0);
    check("R8 pull-up window touch", lastPull, (64 + 40) * C);
    check("R6 touch result with pull-up", dataOut, 8'hC3);

    // R9 cancel
    setPull(40);
    setPull(0);
    devByte = 8'hFF;
    runOp(3, 8'hA5, 1, 1'b0);
    check("R9 cancelled request", lastPull, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule